// File: doc/BRIEF.md
# 256-Color Scanout Address Generator

This block turns the raster position of each displayed pixel into the byte address that the display fetch logic must read from video memory in 256-color graphics modes. Video memory is modelled as four 64 KiB planes seen as one flat 18-bit byte space, with the plane number in the top two address bits. Two memory layouts are supported. In the linear-chained layout, neighbouring pixels rotate across the planes and keep their column position within each group of four. In the planar layout, neighbouring pixels rotate across the planes and the column advances once every four pixels.

The raster counter presents a pixel coordinate together with a strobe. One clock later the block returns the address with a valid flag. The display start address, the row-pitch register, the layout select and the line-doubling select are taken from the register file only on a frame-start pulse. A register write in the middle of a frame therefore cannot change the addressing partway down the screen.

Top module: `vga256_scan_addr`

## Requirements
- R1: The display start address is {start_hi, start_lo} (start_hi in bits 15:8) and is added to every computed address.
- R2: With chain_mode = 1, the row pitch in bytes is row_offset × 8.
- R3: With chain_mode = 0, the row pitch in bytes is row_offset × 2.
- R4: The memory pixel index is pix_x >> 1, so screen columns 2k and 2k+1 yield the same address.
- R5: With dbl_scan = 1 the memory row is pix_y >> 1; with dbl_scan = 0 it is pix_y.
- R6: The plane is (memory pixel index mod 4) and adds plane × 65536 to the address.
- R7: In chained mode the column term is the memory pixel index with its two low bits cleared.
- R8: In planar mode the column term is the memory pixel index >> 2.
- R9: The address is start + plane×65536 + row×pitch + column, taken modulo 2^18.
- R10: addr_valid is high exactly in the cycle after a cycle with pix_valid high, and mem_addr holds that pixel's address in that cycle.
- R11: start_hi, start_lo, row_offset, chain_mode and dbl_scan take effect only at a clock edge where frame_start is high; changes at other times do not affect the addresses.
- R12: After reset, addr_valid and mem_addr are 0 and the captured settings are all zero (start 0, pitch 0, planar layout, no line doubling).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | Pulse that captures the display settings |
| start_hi | input | 8 | Display start address, upper byte |
| start_lo | input | 8 | Display start address, lower byte |
| row_offset | input | 8 | Row-pitch register |
| chain_mode | input | 1 | 1 = chained layout, 0 = planar layout |
| dbl_scan | input | 1 | 1 = each memory row is shown on two lines |
| pix_valid | input | 1 | Pixel coordinate strobe |
| pix_x | input | X_W | Screen column |
| pix_y | input | Y_W | Screen line |
| addr_valid | output | 1 | Address valid, one cycle after pix_valid |
| mem_addr | output | ADDR_W | Flat video memory byte address |

## Verification
The bench uses the default parameters: 10-bit screen coordinates and an 18-bit address. Coordinates up to 1023, together with the largest pitch register and start address, give raw sums well beyond 2^18, so the wrap case can be reached. The narrow 10-bit coordinates still cover a full low-resolution screen in both layouts. The same checks therefore compare chained and planar column placement, line doubling on and off, and pixel pairing at the edges of such a screen.

// File: rtl/vga256_pkg.sv
// Package: shared constants and the captured-settings record for the
// 256-color scanout addresser. Assumes byte-wide display registers.
package vga256_pkg;

    localparam int PLANE_BITS  = 2;
    localparam int PLANE_SHIFT = 16;
    localparam int REG_W       = 8;
    localparam int START_W     = 2 * REG_W;
    localparam int CHAIN_SH    = 3;
    localparam int PLANAR_SH   = 1;
    localparam int PITCH_W     = REG_W + CHAIN_SH;

    typedef struct packed {
        logic [START_W-1:0] start;
        logic [REG_W-1:0]   pitch_reg;
        logic               chained;
        logic               line_dbl;
    } scan_cfg_t;

endpackage

// File: rtl/vga256_cfg_shadow.sv
// Module: holds the display settings for one frame. The live register
// values are copied only on frame_start, so writes in the middle of a frame
// wait for the next frame. Assumes frame_start is synchronous to clk.
module vga256_cfg_shadow
    import vga256_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic [REG_W-1:0] start_hi,
    input  logic [REG_W-1:0] start_lo,
    input  logic [REG_W-1:0] row_offset,
    input  logic             chain_mode,
    input  logic             dbl_scan,
    output scan_cfg_t        cfg
);

    scan_cfg_t live_cfg;

    // Assemble the live register values into one record.
    always_comb begin
        live_cfg.start     = {start_hi, start_lo};
        live_cfg.pitch_reg = row_offset;
        live_cfg.chained   = chain_mode;
        live_cfg.line_dbl  = dbl_scan;
    end

    // Capture the live settings at each frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (frame_start) begin
            cfg <= live_cfg;
        end
    end

    // R11: settings hold between frame boundaries.
    assert_cfg_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(cfg));

    // R11: a frame boundary loads what the register inputs showed.
    assert_cfg_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (cfg.start == $past({start_hi, start_lo}))
                        && (cfg.pitch_reg == $past(row_offset)));

endmodule

// File: rtl/vga256_coord_map.sv
// Module: maps a screen coordinate to memory terms: the plane, the memory
// row and the column term for the selected layout. Each memory pixel is
// shown twice horizontally. Assumes X_W >= 4.
module vga256_coord_map
    import vga256_pkg::*;
#(
    parameter int X_W = 10,
    parameter int Y_W = 10
) (
    input  logic                  chained,
    input  logic                  line_dbl,
    input  logic [X_W-1:0]        pix_x,
    input  logic [Y_W-1:0]        pix_y,
    output logic [PLANE_BITS-1:0] plane,
    output logic [Y_W-1:0]        mem_row,
    output logic [X_W-2:0]        col_term
);

    localparam int IDX_W = X_W - 1;

    logic [IDX_W-1:0] pix_idx;
    logic             unused_lsb;

    assign unused_lsb = pix_x[0];

    // Halve the screen column to get the memory pixel index.
    always_comb pix_idx = pix_x[X_W-1:1];

    // The low two bits of the index select the plane.
    always_comb plane = pix_idx[PLANE_BITS-1:0];

    // With line doubling on, two screen lines share one memory row.
    always_comb mem_row = line_dbl ? (pix_y >> 1) : pix_y;

    // Column term depends on the layout.
    always_comb begin
        if (chained) begin
            col_term = {pix_idx[IDX_W-1:PLANE_BITS], {PLANE_BITS{1'b0}}};
        end else begin
            col_term = pix_idx >> PLANE_BITS;
        end
    end

endmodule

// File: rtl/vga256_addr_calc.sv
// Module: sums the start address, the plane base, the row base and the
// column term, and wraps the result to ADDR_W bits. Purely combinational.
module vga256_addr_calc
    import vga256_pkg::*;
#(
    parameter int X_W    = 10,
    parameter int Y_W    = 10,
    parameter int ADDR_W = 18
) (
    input  scan_cfg_t             cfg,
    input  logic [PLANE_BITS-1:0] plane,
    input  logic [Y_W-1:0]        mem_row,
    input  logic [X_W-2:0]        col_term,
    output logic [ADDR_W-1:0]     addr
);

    localparam int PROD_W = Y_W + PITCH_W;
    localparam int BASE_W = (PROD_W > ADDR_W) ? PROD_W : ADDR_W;
    localparam int SUM_W  = BASE_W + 2;

    logic [PITCH_W-1:0] pitch;
    logic [SUM_W-1:0]   row_base;
    logic [SUM_W-1:0]   plane_base;
    logic [SUM_W-1:0]   total;

    // Row pitch in bytes depends on the layout.
    always_comb begin
        if (cfg.chained) begin
            pitch = PITCH_W'(cfg.pitch_reg) << CHAIN_SH;
        end else begin
            pitch = PITCH_W'(cfg.pitch_reg) << PLANAR_SH;
        end
    end

    // Byte offset of the start of the memory row.
    always_comb row_base = SUM_W'(mem_row) * SUM_W'(pitch);

    // Plane base: each plane spans 64 KiB of the flat space.
    always_comb plane_base = SUM_W'(plane) << PLANE_SHIFT;

    // Add all the terms.
    always_comb total = SUM_W'(cfg.start) + plane_base + row_base + SUM_W'(col_term);

    // Keep the address inside the plane space.
    always_comb addr = total[ADDR_W-1:0];

endmodule

// File: rtl/vga256_scan_addr.sv
// Module: top of the 256-color scanout addresser. Captures the settings per
// frame, maps each strobed coordinate, and registers the address with a
// one-cycle latency. Assumes a new coordinate may come every clock.
module vga256_scan_addr
    import vga256_pkg::*;
#(
    parameter int X_W    = 10,
    parameter int Y_W    = 10,
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic [7:0]        start_hi,
    input  logic [7:0]        start_lo,
    input  logic [7:0]        row_offset,
    input  logic              chain_mode,
    input  logic              dbl_scan,
    input  logic              pix_valid,
    input  logic [X_W-1:0]    pix_x,
    input  logic [Y_W-1:0]    pix_y,
    output logic              addr_valid,
    output logic [ADDR_W-1:0] mem_addr
);

    scan_cfg_t             cfg;
    logic [PLANE_BITS-1:0] plane;
    logic [Y_W-1:0]        mem_row;
    logic [X_W-2:0]        col_term;
    logic [ADDR_W-1:0]     next_addr;

    vga256_cfg_shadow u_shadow (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .start_hi    (start_hi),
        .start_lo    (start_lo),
        .row_offset  (row_offset),
        .chain_mode  (chain_mode),
        .dbl_scan    (dbl_scan),
        .cfg         (cfg)
    );

    vga256_coord_map #(.X_W(X_W), .Y_W(Y_W)) u_map (
        .chained  (cfg.chained),
        .line_dbl (cfg.line_dbl),
        .pix_x    (pix_x),
        .pix_y    (pix_y),
        .plane    (plane),
        .mem_row  (mem_row),
        .col_term (col_term)
    );

    vga256_addr_calc #(.X_W(X_W), .Y_W(Y_W), .ADDR_W(ADDR_W)) u_calc (
        .cfg      (cfg),
        .plane    (plane),
        .mem_row  (mem_row),
        .col_term (col_term),
        .addr     (next_addr)
    );

    // Output stage: one register between the strobe and the address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_valid <= 1'b0;
            mem_addr   <= '0;
        end else begin
            addr_valid <= pix_valid;
            if (pix_valid) begin
                mem_addr <= next_addr;
            end
        end
    end

    // R10: every strobe yields a valid address one cycle later.
    assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> addr_valid);

    // R10: no valid address without a strobe.
    assert_no_spurious_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> !addr_valid);

    // R10: the address is held while no strobe arrives.
    assert_addr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> $stable(mem_addr));

endmodule

// File: tb/vga256_scan_addr_bench.sv
// Directed bench for the 256-color scanout addresser.
module vga256_scan_addr_bench;

    localparam int X_W    = 10;
    localparam int Y_W    = 10;
    localparam int ADDR_W = 18;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              frame_start = 1'b0;
    logic [7:0]        start_hi = '0;
    logic [7:0]        start_lo = '0;
    logic [7:0]        row_offset = '0;
    logic              chain_mode = 1'b0;
    logic              dbl_scan = 1'b0;
    logic              pix_valid = 1'b0;
    logic [X_W-1:0]    pix_x = '0;
    logic [Y_W-1:0]    pix_y = '0;
    logic              addr_valid;
    logic [ADDR_W-1:0] mem_addr;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Settings the design should currently be using.
    int  m_hi = 0, m_lo = 0, m_off = 0;
    bit  m_chain = 1'b0, m_dbl = 1'b0;

    always #2 clk = ~clk;

    vga256_scan_addr #(.X_W(X_W), .Y_W(Y_W), .ADDR_W(ADDR_W)) u_vga256_scan_addr (
        .clk (clk), .rst_n (rst_n), .frame_start (frame_start),
        .start_hi (start_hi), .start_lo (start_lo), .row_offset (row_offset),
        .chain_mode (chain_mode), .dbl_scan (dbl_scan),
        .pix_valid (pix_valid), .pix_x (pix_x), .pix_y (pix_y),
        .addr_valid (addr_valid), .mem_addr (mem_addr)
    );

    // Address expected from the requirement formulas.
    function automatic int exp_addr(int x, int y);
        int idx, row, pitch, pl, col;
        idx   = x / 2;
        row   = m_dbl ? y / 2 : y;
        pitch = m_chain ? m_off * 8 : m_off * 2;
        pl    = idx % 4;
        col   = m_chain ? idx - pl : idx / 4;
        return (m_hi * 256 + m_lo + pl * 65536 + row * pitch + col) % 262144;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Load settings on the ports and pulse frame_start for one cycle.
    task automatic new_frame(int hi, int lo, int off, bit ch, bit db);
        @(negedge clk);
        start_hi = 8'(hi); start_lo = 8'(lo); row_offset = 8'(off);
        chain_mode = ch; dbl_scan = db; frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        m_hi = hi; m_lo = lo; m_off = off; m_chain = ch; m_dbl = db;
    endtask

    // Present one pixel and check its registered address.
    task automatic pixel(string req, int x, int y);
        @(negedge clk);
        pix_valid = 1'b1; pix_x = X_W'(x); pix_y = Y_W'(y);
        @(negedge clk);
        pix_valid = 1'b0;
        check({req, " valid"}, int'(addr_valid), 1);
        check(req, int'(mem_addr), exp_addr(x, y));
    endtask

    task automatic t_reset;
        check("R12 valid after reset", int'(addr_valid), 0);
        check("R12 addr after reset", int'(mem_addr), 0);
        pixel("R12 zero settings", 13, 5);
    endtask

    task automatic t_chained;
        new_frame(0, 0, 40, 1'b1, 1'b1);
        pixel("R2 R7 chained origin", 0, 0);
        pixel("R4 pixel pair", 1, 0);
        pixel("R6 R7 chained plane", 7, 3);
        pixel("R2 R5 chained corner", 639, 399);
    endtask

    task automatic t_planar;
        new_frame(8'h12, 8'h34, 40, 1'b0, 1'b0);
        pixel("R1 R3 planar start", 0, 0);
        pixel("R8 planar column", 22, 9);
        pixel("R6 R8 planar plane", 13, 100);
        pixel("R4 R8 pair partner", 12, 100);
    endtask

    task automatic t_dbl;
        new_frame(0, 8'h10, 20, 1'b1, 1'b1);
        pixel("R5 doubled even", 10, 6);
        pixel("R5 doubled odd", 10, 7);
        new_frame(0, 8'h10, 20, 1'b1, 1'b0);
        pixel("R5 single odd", 10, 7);
    endtask

    task automatic t_wrap;
        new_frame(8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b0);
        pixel("R9 wrap chained", 1023, 1023);
        new_frame(8'hFF, 8'hF0, 8'hFF, 1'b0, 1'b0);
        pixel("R9 wrap planar", 1021, 700);
    endtask

    task automatic t_midframe;
        new_frame(8'h01, 8'h00, 30, 1'b0, 1'b0);
        @(negedge clk);
        start_hi = 8'h40; row_offset = 8'd90; chain_mode = 1'b1; dbl_scan = 1'b1;
        pixel("R11 mid-frame write ignored", 50, 20);
        new_frame(8'h40, 8'h00, 90, 1'b1, 1'b1);
        pixel("R11 applied at frame start", 50, 20);
    endtask

    task automatic t_valid;
        new_frame(0, 8'h20, 10, 1'b0, 1'b0);
        @(negedge clk);
        check("R10 idle no valid", int'(addr_valid), 0);
        pix_valid = 1'b1; pix_x = 10'd100; pix_y = 10'd3;
        @(negedge clk);
        check("R10 back-to-back first valid", int'(addr_valid), 1);
        check("R10 back-to-back first", int'(mem_addr), exp_addr(100, 3));
        pix_x = 10'd102;
        @(negedge clk);
        pix_valid = 1'b0;
        check("R10 back-to-back second valid", int'(addr_valid), 1);
        check("R10 back-to-back second", int'(mem_addr), exp_addr(102, 3));
        @(negedge clk);
        check("R10 valid drops", int'(addr_valid), 0);
        check("R10 addr held", int'(mem_addr), exp_addr(102, 3));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_chained();
        t_planar();
        t_dbl();
        t_wrap();
        t_midframe();
        t_valid();
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual hung expected done");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule